// File: doc/BRIEF.md
# Split-Phase 16-bit ISA Data Bridge

This block lets a host with an 8-bit data bus run full 16-bit data transfers on an ISA-style bus. It pairs one byte-wide data path with a holding register for the upper byte. Host accesses come in two kinds. A "low" access starts an ISA cycle. A "high" access only touches the holding register.

For a write, the host first loads the upper byte into the holding register. A low-byte write then starts an ISA write cycle. That cycle drives the host byte on ISA D[7:0] and the held byte on ISA D[15:8] together.

For a read, a low-byte read starts an ISA read cycle. When the cycle ends, ISA D[7:0] goes back to the host and ISA D[15:8] is captured into the holding register. The host reads that byte later with a high-byte read. It must do so before the next ISA read overwrites it.

Each ISA cycle holds its strobe for a minimum number of clocks. If the ISA ready line is low when that minimum is reached, the cycle is stretched and a stall output holds the host off. The stall lasts until ready returns.

Top module: `isa_wide_bridge`

## Requirements
- R1: After synchronous reset, isa_rd, isa_wr, isa_d_oe and host_stall are 0, host_dout is 0x00, and the holding register is 0x00 (a high read then returns 0x00).
- R2: A high-byte write (host_sel_hi=1, host_rd=0, host_sel_lo=0) stores host_din in the holding register. A high-byte read (host_sel_hi=1, host_rd=1) presents the holding register on host_dout from the next cycle. Neither access raises isa_rd or isa_wr.
- R3: A low-byte write (host_sel_lo=1, host_rd=0) raises isa_wr from the next cycle for STROBE_CYC cycles while isa_ready is 1. During that time isa_d_out = {holding register, host_din}, with the held byte in bits 15:8.
- R4: A low-byte read (host_sel_lo=1, host_rd=1) raises isa_rd for STROBE_CYC cycles while isa_ready is 1. In the cycle after it ends, host_dout = isa_d_in[7:0] and the holding register holds isa_d_in[15:8].
- R5: isa_d_oe is 1 exactly while isa_wr is 1. It is 0 during read cycles and when idle.
- R6: If isa_ready is 0 when the minimum strobe length is reached, the strobe stays active and host_stall rises. Both host_stall and the strobe fall one cycle after isa_ready is seen at 1.
- R7: Host accesses of either kind made while an ISA cycle is active are ignored. They change neither the holding register nor the bus activity.
- R8: When host_sel_lo and host_sel_hi are both 1 in the same cycle, the low access wins and the high access is ignored.
- R9: isa_rd and isa_wr are never 1 at the same time.
- R10: Every ISA read replaces the holding register with the new upper byte. A later high read returns the most recent one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_lo | input | 1 | Low-byte access select; starts an ISA cycle |
| host_sel_hi | input | 1 | Holding-register access select |
| host_rd | input | 1 | 1 = read, 0 = write for the selected access |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data (registered) |
| host_stall | output | 1 | Holds the host off while an ISA cycle is stretched |
| isa_rd | output | 1 | ISA read strobe, active high |
| isa_wr | output | 1 | ISA write strobe, active high |
| isa_ready | input | 1 | ISA ready; 0 stretches the cycle |
| isa_d_in | input | 16 | ISA data bus as received |
| isa_d_out | output | 16 | ISA data bus to drive |
| isa_d_oe | output | 1 | Output enable for isa_d_out |

## Verification
The colliding functions are a low-byte access and a holding-register access that arrive in the same cycle. With a write, the two would compete to set the upper byte of the ISA word. With a read, they would compete for host_dout. The bench raises both selects together in each direction. It then checks that the ISA word carries the previously held byte and that host_dout carries the ISA low byte. A later high read confirms that the holding register kept its earlier value after a write, or took the captured ISA byte after a read. The same question is asked of accesses made while a stretched cycle is still open; these must leave no trace.

// File: rtl/isa_bridge_pkg.sv
package isa_bridge_pkg;

  typedef enum logic {
    CYC_IDLE   = 1'b0,
    CYC_ACTIVE = 1'b1
  } cyc_state_t;

  typedef struct packed {
    logic launch;     // start an ISA cycle
    logic launch_rd;  // started cycle is a read
    logic hold_wr;    // load holding register from host
    logic hold_rd;    // return holding register to host
  } host_cmd_t;

endpackage

// File: rtl/host_cmd_decode.sv
module host_cmd_decode
  import isa_bridge_pkg::*;
(
  input  logic      sel_lo,
  input  logic      sel_hi,
  input  logic      rd,
  input  logic      busy,
  output host_cmd_t cmd
);

  always_comb begin
    cmd = '0;
    if (!busy) begin
      if (sel_lo) begin
        // low access has priority over a simultaneous high access
        cmd.launch    = 1'b1;
        cmd.launch_rd = rd;
      end else if (sel_hi) begin
        cmd.hold_wr = !rd;
        cmd.hold_rd = rd;
      end
    end
  end

endmodule

// File: rtl/isa_cycle_ctrl.sv
module isa_cycle_ctrl
  import isa_bridge_pkg::*;
#(
  parameter int STROBE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_rd,
  input  logic ready,
  output logic busy,
  output logic finish,
  output logic rd_stb,
  output logic wr_stb,
  output logic stall
);

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYC - 1);

  cyc_state_t       state;
  logic [CNT_W-1:0] cnt;

  assign busy   = (state == CYC_ACTIVE);
  assign finish = busy && (cnt == LAST) && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CYC_IDLE;
      cnt    <= '0;
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
      stall  <= 1'b0;
    end else begin
      case (state)
        CYC_IDLE: begin
          if (start) begin
            state  <= CYC_ACTIVE;
            cnt    <= '0;
            rd_stb <= start_rd;
            wr_stb <= !start_rd;
          end
        end
        CYC_ACTIVE: begin
          if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
          end else if (ready) begin
            state  <= CYC_IDLE;
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            stall  <= 1'b0;
          end else begin
            stall <= 1'b1;
          end
        end
        default: state <= CYC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/isa_data_path.sv
module isa_data_path
  import isa_bridge_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  host_cmd_t           cmd,
  input  logic                finish,
  input  logic                cyc_is_rd,
  input  logic [BYTE_W-1:0]   host_din,
  input  logic [2*BYTE_W-1:0] bus_in,
  output logic [BYTE_W-1:0]   host_dout,
  output logic [2*BYTE_W-1:0] bus_out,
  output logic                bus_oe
);

  logic [BYTE_W-1:0] hold_q;

  // holding register: host load or capture of the ISA upper byte
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (finish && cyc_is_rd) begin
      hold_q <= bus_in[2*BYTE_W-1:BYTE_W];
    end else if (cmd.hold_wr) begin
      hold_q <= host_din;
    end
  end

  // host read data
  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '0;
    end else if (finish && cyc_is_rd) begin
      host_dout <= bus_in[BYTE_W-1:0];
    end else if (cmd.hold_rd) begin
      host_dout <= hold_q;
    end
  end

  // ISA drive word and enable
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      bus_oe  <= 1'b0;
    end else if (cmd.launch) begin
      if (!cmd.launch_rd) begin
        bus_out <= {hold_q, host_din};
      end
      bus_oe <= !cmd.launch_rd;
    end else if (finish) begin
      bus_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/isa_wide_bridge.sv
module isa_wide_bridge
  import isa_bridge_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int STROBE_CYC = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_sel_lo,
  input  logic                host_sel_hi,
  input  logic                host_rd,
  input  logic [BYTE_W-1:0]   host_din,
  output logic [BYTE_W-1:0]   host_dout,
  output logic                host_stall,
  output logic                isa_rd,
  output logic                isa_wr,
  input  logic                isa_ready,
  input  logic [2*BYTE_W-1:0] isa_d_in,
  output logic [2*BYTE_W-1:0] isa_d_out,
  output logic                isa_d_oe
);

  host_cmd_t cmd;
  logic      busy;
  logic      finish;

  host_cmd_decode u_decode (
    .sel_lo (host_sel_lo),
    .sel_hi (host_sel_hi),
    .rd     (host_rd),
    .busy   (busy),
    .cmd    (cmd)
  );

  isa_cycle_ctrl #(
    .STROBE_CYC (STROBE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (cmd.launch),
    .start_rd (cmd.launch_rd),
    .ready    (isa_ready),
    .busy     (busy),
    .finish   (finish),
    .rd_stb   (isa_rd),
    .wr_stb   (isa_wr),
    .stall    (host_stall)
  );

  isa_data_path #(
    .BYTE_W (BYTE_W)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .finish    (finish),
    .cyc_is_rd (isa_rd),
    .host_din  (host_din),
    .bus_in    (isa_d_in),
    .host_dout (host_dout),
    .bus_out   (isa_d_out),
    .bus_oe    (isa_d_oe)
  );

endmodule

// File: rtl/isa_wide_bridge_checker.sv
module isa_wide_bridge_checker #(
  parameter int BYTE_W     = 8,
  parameter int STROBE_CYC = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                host_stall,
  input logic                isa_rd,
  input logic                isa_wr,
  input logic                isa_ready,
  input logic [2*BYTE_W-1:0] isa_d_out,
  input logic                isa_d_oe
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!isa_rd && !isa_wr && !isa_d_oe && !host_stall));

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(isa_rd && isa_wr));

  p_oe_tracks_write_r5: assert property (@(posedge clk) disable iff (rst)
    isa_d_oe == isa_wr);

  p_write_word_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (isa_wr && $past(isa_wr)) |-> $stable(isa_d_out));

  p_min_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(isa_wr || isa_rd) && (STROBE_CYC > 1)) |=> (isa_wr || isa_rd));

  p_stall_inside_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    host_stall |-> (isa_rd || isa_wr));

  p_stall_release_r6: assert property (@(posedge clk) disable iff (rst)
    (host_stall && isa_ready) |=> (!host_stall && !isa_rd && !isa_wr));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (host_stall && !isa_ready) |=> host_stall);

endmodule

bind isa_wide_bridge isa_wide_bridge_checker #(
  .BYTE_W     (BYTE_W),
  .STROBE_CYC (STROBE_CYC)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .host_stall (host_stall),
  .isa_rd     (isa_rd),
  .isa_wr     (isa_wr),
  .isa_ready  (isa_ready),
  .isa_d_out  (isa_d_out),
  .isa_d_oe   (isa_d_oe)
);

// File: tb/isa_wide_bridge_test.sv
module isa_wide_bridge_test;

  localparam int BW = 8;
  localparam int S  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_sel_lo = 1'b0;
  logic          host_sel_hi = 1'b0;
  logic          host_rd = 1'b0;
  logic [BW-1:0] host_din = '0;
  logic [BW-1:0] host_dout;
  logic          host_stall;
  logic          isa_rd, isa_wr, isa_d_oe;
  logic          isa_ready = 1'b1;
  logic [2*BW-1:0] isa_d_in = '0;
  logic [2*BW-1:0] isa_d_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  isa_wide_bridge #(.BYTE_W(BW), .STROBE_CYC(S)) uut (
    .clk(clk), .rst(rst),
    .host_sel_lo(host_sel_lo), .host_sel_hi(host_sel_hi), .host_rd(host_rd),
    .host_din(host_din), .host_dout(host_dout), .host_stall(host_stall),
    .isa_rd(isa_rd), .isa_wr(isa_wr), .isa_ready(isa_ready),
    .isa_d_in(isa_d_in), .isa_d_out(isa_d_out), .isa_d_oe(isa_d_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one-cycle host access, driven and released on falling edges
  task automatic host_op(input logic lo, input logic hi, input logic rd, input logic [7:0] d);
    host_sel_lo = lo; host_sel_hi = hi; host_rd = rd; host_din = d;
    @(negedge clk);
    host_sel_lo = 1'b0; host_sel_hi = 1'b0; host_rd = 1'b0;
  endtask

  task automatic check_hold(input string tag, input logic [7:0] exp);
    host_op(1'b0, 1'b1, 1'b1, 8'h00);
    chk(tag, {8'h00, host_dout}, {8'h00, exp});
  endtask

  task automatic write_cycle(input logic [7:0] hi, input logic [7:0] lo);
    host_op(1'b0, 1'b1, 1'b0, hi);
    chk("R2 no strobe on high write", {14'b0, isa_rd, isa_wr}, 16'h0);
    host_op(1'b1, 1'b0, 1'b0, lo);
    for (int i = 0; i < S; i++) begin
      chk("R3 write strobe", {14'b0, isa_rd, isa_wr}, 16'h1);
      chk("R5 oe in write", {15'b0, isa_d_oe}, 16'h1);
      chk("R3 write word", isa_d_out, {hi, lo});
      @(negedge clk);
    end
    chk("R3 write end", {13'b0, isa_rd, isa_wr, isa_d_oe}, 16'h0);
  endtask

  task automatic read_cycle(input logic [15:0] val);
    isa_d_in = val;
    host_op(1'b1, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < S; i++) begin
      chk("R4 read strobe", {14'b0, isa_rd, isa_wr}, 16'h2);
      chk("R5 oe off in read", {15'b0, isa_d_oe}, 16'h0);
      @(negedge clk);
    end
    chk("R4 read end", {14'b0, isa_rd, isa_wr}, 16'h0);
    chk("R4 low byte to host", {8'h00, host_dout}, {8'h00, val[7:0]});
    check_hold("R10 high byte captured", val[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes/oe/stall", {12'b0, isa_rd, isa_wr, isa_d_oe, host_stall}, 16'h0);
    chk("R1 host_dout", {8'h00, host_dout}, 16'h0);
    check_hold("R1 holding register", 8'h00);

    // R2 holding register round trip
    host_op(1'b0, 1'b1, 1'b0, 8'hC3);
    check_hold("R2 high write/read", 8'hC3);
    chk("R2 no strobe on high read", {14'b0, isa_rd, isa_wr}, 16'h0);

    // R3/R5 write sweep
    for (int i = 0; i < 256; i++) write_cycle(8'(i), 8'(i) ^ 8'hA5);

    // R4/R10 read sweep
    for (int i = 0; i < 256; i++) read_cycle({8'(i) ^ 8'h3C, 8'(255 - i)});

    // R6 stretched cycles in both directions
    for (int w = 1; w <= 4; w++) begin
      for (int d = 0; d < 2; d++) begin
        isa_ready = 1'b0;
        isa_d_in  = {8'(w * 16), 8'(w + 7)};
        if (d == 0) host_op(1'b0, 1'b1, 1'b0, 8'(w));
        host_op(1'b1, 1'b0, d[0], 8'h5E);
        for (int i = 0; i < S; i++) begin
          chk("R6 no stall before minimum", {15'b0, host_stall}, 16'h0);
          @(negedge clk);
        end
        for (int j = 0; j < w; j++) begin
          chk("R6 stall while not ready", {15'b0, host_stall}, 16'h1);
          chk("R6 strobe stretched", {15'b0, isa_rd | isa_wr}, 16'h1);
          if (j == w - 1) isa_ready = 1'b1;
          @(negedge clk);
        end
        chk("R6 release", {13'b0, host_stall, isa_rd, isa_wr}, 16'h0);
        if (d == 1) chk("R6 stretched read data", {8'h00, host_dout}, {8'h00, 8'(w + 7)});
      end
    end

    // R7 accesses during an active cycle are ignored
    host_op(1'b0, 1'b1, 1'b0, 8'h11);
    isa_ready = 1'b0;
    isa_d_in  = 16'hBEEF;
    host_op(1'b1, 1'b0, 1'b1, 8'h00);
    host_op(1'b0, 1'b1, 1'b0, 8'h77);
    host_op(1'b1, 1'b0, 1'b0, 8'h66);
    host_op(1'b0, 1'b1, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    isa_ready = 1'b1;
    @(negedge clk);
    chk("R7 cycle ends, no extra cycle", {13'b0, host_stall, isa_rd, isa_wr}, 16'h0);
    @(negedge clk);
    chk("R7 still idle", {14'b0, isa_rd, isa_wr}, 16'h0);
    chk("R7 host_dout from read", {8'h00, host_dout}, 16'h00EF);
    check_hold("R7 hold not overwritten", 8'hBE);

    // R8 simultaneous selects: write
    host_op(1'b0, 1'b1, 1'b0, 8'h5A);
    host_op(1'b1, 1'b1, 1'b0, 8'h33);
    chk("R8 write word", isa_d_out, 16'h5A33);
    chk("R8 write strobe", {14'b0, isa_rd, isa_wr}, 16'h1);
    repeat (S) @(negedge clk);
    check_hold("R8 hold kept after write", 8'h5A);
    // R8 simultaneous selects: read
    isa_d_in = 16'h9D42;
    host_op(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R8 read strobe", {14'b0, isa_rd, isa_wr}, 16'h2);
    repeat (S) @(negedge clk);
    chk("R8 read low byte", {8'h00, host_dout}, 16'h0042);
    check_hold("R8 hold captured", 8'h9D);

    // R9 exclusivity is checked throughout by the bound checker; spot check
    chk("R9 idle strobes", {14'b0, isa_rd, isa_wr}, 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule